// File: doc/BRIEF.md
# LIN Header Autobaud Bit-Time Measurement

This receive-side block watches a serial line for a LIN-style header and works out the bit time from it. A header is a long low break with a high delimiter after it, then a 0x55 synchronisation character, then one identifier byte. The block times the synchronisation character in module-clock counts. It stores the result as a bit-time value, in clocks per bit. It then samples the identifier byte with that new bit time. When the identifier arrives with a valid stop bit, the block publishes a fixed status code and raises an interrupt.

Software can read the measured bit time and keep it. Later it can switch the block into byte transfer mode and write the same value back through a load port. Serial timing then runs at the rate the header was sent at. In byte transfer mode the header logic is held idle. The load port only accepts values in that mode.

Top module: `lin_autobaud`

## Requirements
- R1: While `btm_mode` is 1, no header is recognised. The header machine is held idle, and `status` and `irq` do not change because of line activity.
- R2: A break is accepted when the line, after the two-stage input synchroniser, stays low for at least 11 × `bit_time` clocks and then goes high. A low run one clock shorter is rejected and the header after it is ignored.
- R3: When a header is received successfully, `status` becomes 0x2C and `irq` becomes 1. With no event pending, `status` is 0x00 and `irq` is 0.
- R4: The span from the first to the fifth falling edge of the 0x55 character is S clocks. On success, `bit_time` is loaded with ((S + 4) >> 3) with bit 0 forced to 0, for example 168→20, 172→22, 179→22.
- R5: The identifier is sampled using the measured value B. The first sample is taken B/2 clocks after its start-bit falling edge, and one sample follows every B clocks after that. The start bit must be low. The eight data bits arrive LSB first and are presented on `id_byte` on success.
- R6: If the stop bit of the identifier is sampled low, the header is dropped. `status`, `irq`, `bit_time` and `id_byte` keep their previous values.
- R7: A one-clock pulse on `stat_rd` returns `status` to 0x00 and `irq` to 0 on the next clock. An `irq` that has not been read stays at 1, and a new success takes priority over a read in the same clock.
- R8: In byte transfer mode, a pulse on `bt_load` writes `bt_load_val` into `bit_time` with bit 0 forced to 0. With `btm_mode` at 0, the load is ignored.
- R9: After reset, `bit_time` is BT_INIT (16), `status` is 0x00, `irq` is 0 and `id_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| btm_mode | input | 1 | 1 selects byte transfer mode, 0 selects LIN header measurement |
| rx | input | 1 | Serial receive line, idle high |
| bt_load | input | 1 | Write strobe for the bit-time register (byte transfer mode only) |
| bt_load_val | input | 12 | Bit-time value to write |
| stat_rd | input | 1 | Status read strobe, clears status and interrupt |
| bit_time | output | 12 | Current bit time in module clocks per bit |
| status | output | 8 | 0x2C after a good header, else 0x00 |
| irq | output | 1 | Header-received interrupt |
| id_byte | output | 8 | Last identifier captured |

## Verification
A level change on `rx` reaches the header machine three clocks after it is driven. That covers two synchroniser stages and the edge register. Header results are registered once more, so `status`, `irq`, `bit_time` and `id_byte` change exactly 4 + B/2 + 9·B clocks after the identifier start bit is driven. Effects of `stat_rd` and `bt_load` appear one clock after the strobe. The bench model stores each expected update with the clock number at which it is due. It compares every output on each falling clock edge against the model, so an update that is early or late by one clock is caught.

// File: rtl/lin_autobaud_pkg.sv
package lin_autobaud_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_DELIM,
    HS_SYNC,
    HS_IDWAIT,
    HS_IDRX
  } hdr_state_t;

  localparam logic [7:0] STAT_NONE  = 8'h00;
  localparam logic [7:0] STAT_ID_OK = 8'h2C;

  // falling edges inside the 0x55 character, 8 bit times apart end to end
  localparam int SYNC_FALLS = 5;
  localparam int SYNC_SHIFT = 3;

endpackage

// File: rtl/lin_rx_front.sv
module lin_rx_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx,
  output logic rx_q,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sync_r;
  logic              prev_r;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_r[0] <= 1'b1;
          else     sync_r[0] <= rx;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_r[i] <= 1'b1;
          else     sync_r[i] <= sync_r[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_r <= 1'b1;
    else     prev_r <= sync_r[STAGES-1];
  end

  assign rx_q = sync_r[STAGES-1];
  assign fall = prev_r & ~sync_r[STAGES-1];
  assign rise = ~prev_r & sync_r[STAGES-1];
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int CNT_W    = 16,
  parameter int BT_W     = 12,
  parameter int BRK_BITS = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_q,
  input  logic            rise,
  input  logic [BT_W-1:0] bit_time,
  output logic            brk_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(BRK_BITS) * CNT_W'(bit_time);

  always_ff @(posedge clk) begin
    if (rst)                   low_cnt <= '0;
    else if (!rx_q) begin
      if (low_cnt != CNT_MAX)  low_cnt <= low_cnt + 1'b1;
    end else                   low_cnt <= '0;
  end

  // low run has just ended: judge its length against the threshold
  assign brk_seen = rise && (low_cnt >= limit);
endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
  import lin_autobaud_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BT_W   = 12,
  parameter int MIN_BT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lin_en,
  input  logic            rx_q,
  input  logic            fall,
  input  logic            brk_seen,
  output logic            hdr_done,
  output logic [BT_W-1:0] meas_bt,
  output logic [7:0]      id_data
);
  localparam logic [BT_W-1:0]  EVEN_MASK = ~BT_W'(1);
  localparam logic [BT_W-1:0]  BT_TOP    = {BT_W{1'b1}} & EVEN_MASK;
  localparam logic [CNT_W-1:0] SPAN_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   BT_TOP_W  = (CNT_W+1)'(BT_TOP);

  hdr_state_t       st;
  logic [CNT_W-1:0] span;
  logic [2:0]       falls;
  logic [BT_W-1:0]  tmr;
  logic [3:0]       bit_n;
  logic [7:0]       shreg;
  logic [CNT_W:0]   span_p1;
  logic [CNT_W:0]   rounded;
  logic [BT_W-1:0]  bt_calc;

  always_comb begin
    span_p1 = {1'b0, span} + 1'b1;
    rounded = (span_p1 + (CNT_W+1)'(4)) >> SYNC_SHIFT;
    if (rounded > BT_TOP_W) bt_calc = BT_TOP;
    else                    bt_calc = rounded[BT_W-1:0] & EVEN_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= HS_IDLE;
      span     <= '0;
      falls    <= '0;
      tmr      <= '0;
      bit_n    <= '0;
      shreg    <= '0;
      meas_bt  <= '0;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      if (!lin_en) begin
        st <= HS_IDLE;
      end else if (brk_seen) begin
        st <= HS_DELIM;
      end else begin
        case (st)
          HS_DELIM: begin
            if (fall) begin
              span  <= '0;
              falls <= 3'd1;
              st    <= HS_SYNC;
            end
          end
          HS_SYNC: begin
            if (span == SPAN_MAX) begin
              st <= HS_IDLE;
            end else begin
              span <= span + 1'b1;
              if (fall) begin
                if (falls == 3'(SYNC_FALLS - 1)) begin
                  meas_bt <= bt_calc;
                  st      <= (bt_calc < BT_W'(MIN_BT)) ? HS_IDLE : HS_IDWAIT;
                end else begin
                  falls <= falls + 1'b1;
                end
              end
            end
          end
          HS_IDWAIT: begin
            if (fall) begin
              tmr   <= meas_bt >> 1;
              bit_n <= '0;
              st    <= HS_IDRX;
            end
          end
          HS_IDRX: begin
            if (tmr == BT_W'(1)) begin
              tmr   <= meas_bt;
              bit_n <= bit_n + 1'b1;
              if (bit_n == 4'd0) begin
                if (rx_q) st <= HS_IDLE;
              end else if (bit_n < 4'd9) begin
                shreg <= {rx_q, shreg[7:1]};
              end else begin
                hdr_done <= rx_q;
                st       <= HS_IDLE;
              end
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          default: st <= HS_IDLE;
        endcase
      end
    end
  end

  assign id_data = shreg;
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
  import lin_autobaud_pkg::*;
#(
  parameter int BT_W     = 12,
  parameter int CNT_W    = 16,
  parameter int BRK_BITS = 11,
  parameter int STAGES   = 2,
  parameter int MIN_BT   = 4,
  parameter int BT_INIT  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btm_mode,
  input  logic            rx,
  input  logic            bt_load,
  input  logic [BT_W-1:0] bt_load_val,
  input  logic            stat_rd,
  output logic [BT_W-1:0] bit_time,
  output logic [7:0]      status,
  output logic            irq,
  output logic [7:0]      id_byte
);
  localparam logic [BT_W-1:0] EVEN_MASK = ~BT_W'(1);
  localparam logic [BT_W-1:0] BT_RST    = BT_W'(BT_INIT) & EVEN_MASK;

  logic            rx_q, fall, rise, brk_seen, hdr_done;
  logic [BT_W-1:0] meas_bt;
  logic [7:0]      id_data;

  lin_rx_front #(.STAGES(STAGES)) u_front (
    .clk(clk), .rst(rst), .rx(rx), .rx_q(rx_q), .fall(fall), .rise(rise)
  );

  lin_brk_det #(.CNT_W(CNT_W), .BT_W(BT_W), .BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst(rst), .rx_q(rx_q), .rise(rise),
    .bit_time(bit_time), .brk_seen(brk_seen)
  );

  lin_hdr_fsm #(.CNT_W(CNT_W), .BT_W(BT_W), .MIN_BT(MIN_BT)) u_fsm (
    .clk(clk), .rst(rst), .lin_en(!btm_mode), .rx_q(rx_q), .fall(fall),
    .brk_seen(brk_seen), .hdr_done(hdr_done), .meas_bt(meas_bt),
    .id_data(id_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_time <= BT_RST;
      status   <= STAT_NONE;
      irq      <= 1'b0;
      id_byte  <= 8'h00;
    end else begin
      if (hdr_done) begin
        status   <= STAT_ID_OK;
        irq      <= 1'b1;
        bit_time <= meas_bt;
        id_byte  <= id_data;
      end else if (stat_rd) begin
        status <= STAT_NONE;
        irq    <= 1'b0;
      end
      if (btm_mode && bt_load) bit_time <= bt_load_val & EVEN_MASK;
    end
  end
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int BT_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            btm_mode,
  input logic            bt_load,
  input logic            stat_rd,
  input logic [BT_W-1:0] bit_time,
  input logic [7:0]      status,
  input logic            irq
);
  // R3: status code and interrupt agree
  a_r3_status_matches_irq: assert property (@(posedge clk) disable iff (rst)
    (irq && status == 8'h2C) || (!irq && status == 8'h00));

  // R4: bit time is always even
  a_r4_bit_time_even: assert property (@(posedge clk) disable iff (rst)
    !bit_time[0]);

  // R1: no header success while byte transfer mode was selected
  a_r1_no_irq_in_btm: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !$past(btm_mode, 2));

  // R7: an unread interrupt stays set
  a_r7_irq_held: assert property (@(posedge clk) disable iff (rst)
    irq && !stat_rd |=> irq);

  // R8: bit time changes only by a mode-gated load or a header success
  a_r8_bt_change_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_time) |-> (($past(bt_load) && $past(btm_mode)) || irq));
endmodule

bind lin_autobaud lin_autobaud_chk #(.BT_W(BT_W)) u_chk (
  .clk(clk), .rst(rst), .btm_mode(btm_mode), .bt_load(bt_load),
  .stat_rd(stat_rd), .bit_time(bit_time), .status(status), .irq(irq)
);

// File: tb/lin_autobaud_test.sv
module lin_autobaud_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btm = 1'b0;
  logic        rx  = 1'b1;
  logic        ld  = 1'b0;
  logic [11:0] ldv = '0;
  logic        rd  = 1'b0;
  logic [11:0] bit_time;
  logic [7:0]  status;
  logic        irq;
  logic [7:0]  id_byte;

  lin_autobaud uut (
    .clk(clk), .rst(rst), .btm_mode(btm), .rx(rx), .bt_load(ld),
    .bt_load_val(ldv), .stat_rd(rd), .bit_time(bit_time),
    .status(status), .irq(irq), .id_byte(id_byte)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference: expected values and due clock numbers
  int m_bt = 16, m_st = 0, m_irq = 0, m_id = 0;
  int p_cyc = -1, p_bt = 0, p_id = 0;
  int c_cyc = -1;
  int l_cyc = -1, l_val = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (c_cyc >= 0 && cyc >= c_cyc) begin m_st = 0; m_irq = 0; c_cyc = -1; end
      if (p_cyc >= 0 && cyc >= p_cyc) begin
        m_st = 'h2C; m_irq = 1; m_bt = p_bt; m_id = p_id; p_cyc = -1;
      end
      if (l_cyc >= 0 && cyc >= l_cyc) begin m_bt = l_val & ~1; l_cyc = -1; end
      chk(int'(bit_time) == m_bt, "R4 bit_time", int'(bit_time), m_bt);
      chk(int'(status) == m_st, "R3 status", int'(status), m_st);
      chk(int'(irq) == m_irq, "R3 irq", int'(irq), m_irq);
      chk(int'(id_byte) == m_id, "R5 id_byte", int'(id_byte), m_id);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input bit v, input int n);
    rx = v;
    step(n);
  endtask

  task automatic header(input int brk, input int t, input int extra,
                        input int id, input bit stop_ok);
    int ca, cb, c0, btn;
    bit ok;
    ok = (btm == 1'b0) && (brk >= 11 * m_bt) && stop_ok;
    drive(1'b0, brk);
    drive(1'b1, 2 * t);
    ca = cyc;
    drive(1'b0, t);
    cb = 0;
    for (int k = 0; k < 8; k++) begin
      if (k == 7) cb = cyc;
      drive((k % 2) == 0, (k == 6) ? t + extra : t);
    end
    drive(1'b1, 2 * t);
    btn = ((cb - ca + 4) >> 3) & ~1;
    c0 = cyc;
    if (ok) begin
      p_bt = btn; p_id = id; p_cyc = c0 + 4 + btn / 2 + 9 * btn;
    end
    drive(1'b0, t);
    for (int k = 0; k < 8; k++) drive(((id >> k) & 1) == 1, t);
    drive(stop_ok, t);
    drive(1'b1, 3 * t + 20);
  endtask

  task automatic read_status();
    rd = 1'b1;
    c_cyc = cyc + 1;
    step(1);
    rd = 1'b0;
    step(2);
  endtask

  task automatic load_bt(input int v);
    ld = 1'b1;
    ldv = 12'(v);
    if (btm) begin l_cyc = cyc + 1; l_val = v; end
    step(1);
    ld = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    step(2);
    chk(bit_time == 12'd16, "R9 reset bit_time", int'(bit_time), 16);
    chk(status == 8'h00 && irq == 1'b0, "R9 reset status", int'(status), 0);

    // R2: one clock under 11 x 16 -> rejected
    header(175, 16, 0, 'h11, 1'b1);
    chk(status == 8'h00, "R2 short break ignored", int'(status), 0);

    // R2/R3/R5: exactly 11 x 16 accepted, 8 x 20 span -> 20
    header(176, 20, 0, 'hA3, 1'b1);
    chk(status == 8'h2C && irq, "R3 header success", int'(status), 'h2C);
    chk(id_byte == 8'hA3, "R5 identifier", int'(id_byte), 'hA3);

    // R4: span 168 -> 21 -> bit 0 cleared -> 20; irq left unread (R7)
    header(250, 21, 0, 'h5A, 1'b1);
    chk(bit_time == 12'd20, "R4 odd result cleared", int'(bit_time), 20);
    chk(irq == 1'b1, "R7 unread irq held", int'(irq), 1);
    read_status();
    chk(status == 8'h00 && !irq, "R7 read clears", int'(status), 0);

    // R4: span 179 rounds down to 22
    header(240, 22, 3, 'hC6, 1'b1);
    chk(bit_time == 12'd22, "R4 round down", int'(bit_time), 22);
    // R4: span 172 rounds up to 22, identifier sampled with 22 at 21-clock bits
    header(300, 21, 4, 'h0F, 1'b1);
    chk(bit_time == 12'd22, "R4 round up", int'(bit_time), 22);
    chk(id_byte == 8'h0F, "R5 sampled with measured bit time", int'(id_byte), 'h0F);
    read_status();

    // R6: low stop bit drops header
    header(300, 22, 0, 'h81, 1'b0);
    chk(status == 8'h00 && id_byte == 8'h0F, "R6 bad stop ignored", int'(id_byte), 'h0F);

    // R1: byte transfer mode ignores a header; R8 load even
    btm = 1'b1;
    step(3);
    header(400, 22, 0, 'h33, 1'b1);
    chk(status == 8'h00 && !irq, "R1 no header in byte mode", int'(status), 0);
    load_bt(21);
    chk(bit_time == 12'd20, "R8 load forces even", int'(bit_time), 20);
    btm = 1'b0;
    step(3);
    load_bt(30);
    chk(bit_time == 12'd20, "R8 load ignored in LIN mode", int'(bit_time), 20);

    // R2: break of exactly 11 x 20 accepted
    header(220, 20, 0, 'h7E, 1'b1);
    chk(status == 8'h2C && id_byte == 8'h7E, "R2 threshold break", int'(id_byte), 'h7E);
    read_status();
    read_status();
    chk(status == 8'h00 && !irq, "R7 read with nothing pending", int'(status), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule